// File: doc/BRIEF.md
# Flag Offset Register File

This block holds the two thresholds that a FIFO's almost-empty and almost-full flags compare against. Each threshold is wider than a byte, so it is kept as a low byte and a high byte. Software cannot address these four bytes directly. Instead, a fixed selection sequence visits them in a set order, and every qualified access steps it to the next byte. The sequence runs empty-low, empty-high, full-low, full-high and then wraps back to empty-low.

The write side runs on the write clock. It takes a byte, a shared configuration-load control and a write enable. The read side runs on the read clock. It uses the same load control and a read enable, and it returns one byte per qualified read edge. Each side keeps its own 2-bit position in the sequence. A position is kept while load is released, so a host can program one or two bytes, go back to normal FIFO traffic, and continue later at the next byte. Each stored byte is trimmed to the bits that the FIFO depth can use. The two assembled thresholds, each log2(DEPTH) bits wide, go straight to the flag logic.

Both ports use plain level controls sampled on their own clock edge. There is no valid/ready back-pressure, because an access always completes in the cycle it is presented. Reading and writing the register file in the same period is not supported.

Top module: `flag_offset_regs`

## Requirements
- R1: While reset is asserted and after it is released, the empty and full thresholds are both 7, the read byte output is 0, and both sequence positions point at the empty-low byte. The first qualified read after reset therefore returns 0x07.
- R2: On a write-clock rising edge with load high and write enable high, the input byte is stored into the selected register and the write position advances. The bytes are visited in this order: 0 = empty-low, 1 = empty-high, 2 = full-low, 3 = full-high. The empty threshold is {empty-high, empty-low} and the full threshold is {full-high, full-low}. The new value is visible on the threshold outputs after that same edge.
- R3: The qualified write that follows a write to the full-high byte stores into the empty-low byte.
- R4: A write-clock edge with load high and write enable low stores nothing and does not move the write position.
- R5: While load is low, write enable is ignored. No byte changes and the write position is kept. When load is raised again, writing resumes at the next byte in the sequence.
- R6: On a read-clock rising edge with load high and read enable high, the selected byte is placed on the read byte output after that edge, and the read position advances in the same order as the write position, wrapping from full-high to empty-low. The read position is independent of the write position.
- R7: On a read-clock edge without both load and read enable high, the read byte output holds its value and the read position does not move.
- R8: Each stored byte keeps only the bits the depth allows. A low byte keeps min(log2(DEPTH), 8) bits. A high byte keeps log2(DEPTH) - 8 bits, or none when log2(DEPTH) is 8 or less. Masked bits read back as 0. At the default DEPTH of 4096, writing 0xFF to a high byte reads back as 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| cfg_load | input | 1 | High selects offset-register access instead of FIFO traffic |
| wr_en | input | 1 | Write enable (write-clock domain) |
| wr_byte | input | 8 | Byte to store |
| rd_en | input | 1 | Read enable (read-clock domain) |
| rd_byte | output | 8 | Last byte read back |
| empty_ofs | output | log2(DEPTH) | Assembled almost-empty threshold |
| full_ofs | output | log2(DEPTH) | Assembled almost-full threshold |

## Verification
The threshold outputs change one write-clock edge after a qualified write. The bench applies each write at a falling edge, lets one rising edge pass, and compares both thresholds at the next falling edge. That comparison also checks that a non-qualified edge left them unchanged. The read byte behaves the same way on the read clock, one edge after a qualified read, and the bench compares it at the falling edge that follows. Each enable is dropped before the next rising edge, so every access covers exactly one edge and the bench's model of the sequence positions stays aligned with the design.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;

  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  localparam logic [7:0] RESET_OFS = 8'd7;

  // Keep the low 'bits' bits of a byte (0 to 8).
  function automatic logic [7:0] byte_mask(input int bits);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < bits) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/flag_offset_seq.sv
module flag_offset_seq
  import flag_offset_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  output ofs_sel_e sel
);

  ofs_sel_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= SEL_E_LO;
    else if (step) sel_q <= ofs_sel_e'(sel_q + 2'd1);
  end

  assign sel = sel_q;

endmodule

// File: rtl/flag_offset_bank.sv
module flag_offset_bank
  import flag_offset_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_go,
  input  ofs_sel_e        sel,
  input  logic [7:0]      din,
  output logic [3:0][7:0] bytes,
  output logic [AW-1:0]   empty_ofs,
  output logic [AW-1:0]   full_ofs
);

  localparam int LO_W = (AW < 8) ? AW : 8;
  localparam int HI_W = (AW > 8) ? AW - 8 : 0;
  localparam logic [7:0] LO_MASK = byte_mask(LO_W);
  localparam logic [7:0] HI_MASK = byte_mask(HI_W);

  // One register per byte; even slots are low bytes, odd slots high bytes.
  for (genvar g = 0; g < 4; g++) begin : g_byte
    localparam logic [7:0] MASK = (g % 2 == 0) ? LO_MASK : HI_MASK;
    localparam logic [7:0] INIT = (g % 2 == 0) ? (RESET_OFS & LO_MASK) : 8'd0;
    logic [7:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= INIT;
      else if (wr_go && (sel == ofs_sel_e'(g))) q <= din & MASK;
    end

    assign bytes[g] = q;
  end

  assign empty_ofs = AW'({bytes[SEL_E_HI], bytes[SEL_E_LO]});
  assign full_ofs  = AW'({bytes[SEL_F_HI], bytes[SEL_F_LO]});

endmodule

// File: rtl/flag_offset_rdport.sv
module flag_offset_rdport
  import flag_offset_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_go,
  input  ofs_sel_e        sel,
  input  logic [3:0][7:0] bytes,
  output logic [7:0]      dout
);

  logic [7:0] dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout_q <= 8'd0;
    else if (rd_go) dout_q <= bytes[sel];
  end

  assign dout = dout_q;

endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs
  import flag_offset_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          rd_en,
  output logic [7:0]    rd_byte,
  output logic [AW-1:0] empty_ofs,
  output logic [AW-1:0] full_ofs
);

  logic            wr_go;
  logic            rd_go;
  ofs_sel_e        w_sel;
  ofs_sel_e        r_sel;
  logic [3:0][7:0] bytes;

  assign wr_go = cfg_load && wr_en;
  assign rd_go = cfg_load && rd_en;

  flag_offset_seq u_wseq (
    .clk  (wclk),
    .rst_n(rst_n),
    .step (wr_go),
    .sel  (w_sel)
  );

  flag_offset_seq u_rseq (
    .clk  (rclk),
    .rst_n(rst_n),
    .step (rd_go),
    .sel  (r_sel)
  );

  flag_offset_bank #(.DEPTH(DEPTH)) u_bank (
    .clk      (wclk),
    .rst_n    (rst_n),
    .wr_go    (wr_go),
    .sel      (w_sel),
    .din      (wr_byte),
    .bytes    (bytes),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs)
  );

  flag_offset_rdport u_rd (
    .clk  (rclk),
    .rst_n(rst_n),
    .rd_go(rd_go),
    .sel  (r_sel),
    .bytes(bytes),
    .dout (rd_byte)
  );

endmodule

// File: rtl/flag_offset_regs_chk.sv
module flag_offset_regs_chk
  import flag_offset_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          wr_en,
  input logic [7:0]    wr_byte,
  input logic          rd_en,
  input logic [7:0]    rd_byte,
  input logic [AW-1:0] empty_ofs,
  input logic [AW-1:0] full_ofs,
  input ofs_sel_e      w_sel,
  input ofs_sel_e      r_sel
);

  localparam logic [7:0] LO_MASK = byte_mask((AW < 8) ? AW : 8);
  localparam logic [7:0] HI_MASK = byte_mask((AW > 8) ? AW - 8 : 0);

  // R2: a write to the empty-low slot shows up in the empty threshold.
  a_r2_store_elo: assert property (@(posedge wclk) disable iff (!rst_n)
    (cfg_load && wr_en && w_sel == SEL_E_LO)
      |=> ((8'(empty_ofs) & LO_MASK) == ($past(wr_byte) & LO_MASK)));

  // R3: the write position steps by one and wraps after full-high.
  a_r3_sel_wraps: assert property (@(posedge wclk) disable iff (!rst_n)
    (cfg_load && wr_en) |=> (w_sel == ofs_sel_e'($past(w_sel) + 2'd1)));

  // R4 / R5: thresholds and write position hold without a qualified write.
  a_r4_ofs_hold: assert property (@(posedge wclk) disable iff (!rst_n)
    !(cfg_load && wr_en) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(w_sel)));

  // R6: the read position advances on each qualified read.
  a_r6_rd_advance: assert property (@(posedge rclk) disable iff (!rst_n)
    (cfg_load && rd_en) |=> (r_sel == ofs_sel_e'($past(r_sel) + 2'd1)));

  // R7: the read byte holds without a qualified read.
  a_r7_rd_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    !(cfg_load && rd_en) |=> ($stable(rd_byte) && $stable(r_sel)));

  // R8: bytes read from high slots carry no bits beyond the depth.
  a_r8_hi_masked: assert property (@(posedge rclk) disable iff (!rst_n)
    (cfg_load && rd_en && (r_sel == SEL_E_HI || r_sel == SEL_F_HI))
      |=> ((rd_byte & ~HI_MASK) == 8'd0));

endmodule

bind flag_offset_regs flag_offset_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk     (wclk),
  .rclk     (rclk),
  .rst_n    (rst_n),
  .cfg_load (cfg_load),
  .wr_en    (wr_en),
  .wr_byte  (wr_byte),
  .rd_en    (rd_en),
  .rd_byte  (rd_byte),
  .empty_ofs(empty_ofs),
  .full_ofs (full_ofs),
  .w_sel    (w_sel),
  .r_sel    (r_sel)
);

// File: tb/flag_offset_regs_bench.sv
module flag_offset_regs_bench;

  localparam int DEPTH = 4096;
  localparam int AW    = $clog2(DEPTH);

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_byte = 8'd0;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_byte;
  logic [AW-1:0] empty_ofs;
  logic [AW-1:0] full_ofs;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench model.
  logic [7:0] m [4];
  int         wpos;
  int         rpos;
  logic [7:0] exp_rd;

  flag_offset_regs #(.DEPTH(DEPTH)) u_flag_offset_regs (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .wr_en    (wr_en),
    .wr_byte  (wr_byte),
    .rd_en    (rd_en),
    .rd_byte  (rd_byte),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs)
  );

  always #4 wclk = ~wclk;
  initial begin
    #2;
    forever #4 rclk = ~rclk;
  end

  function automatic logic [7:0] keep_mask(input int slot);
    int bits;
    bits = (slot % 2 == 0) ? ((AW < 8) ? AW : 8) : ((AW > 8) ? AW - 8 : 0);
    return 8'((1 << bits) - 1);
  endfunction

  function automatic logic [AW-1:0] exp_ofs(input int lo_slot);
    logic [15:0] v;
    v = {m[lo_slot + 1], m[lo_slot]};
    return v[AW-1:0];
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_reset();
    m[0] = 8'd7 & keep_mask(0);
    m[1] = 8'd0;
    m[2] = 8'd7 & keep_mask(2);
    m[3] = 8'd0;
    wpos = 0;
    rpos = 0;
    exp_rd = 8'd0;
  endtask

  task automatic check_ofs(input string req);
    check(req, int'(empty_ofs), int'(exp_ofs(0)));
    check(req, int'(full_ofs), int'(exp_ofs(2)));
  endtask

  // One write-clock access: drive at a falling edge, drop at the next.
  task automatic wr_op(input logic ld, input logic en, input logic [7:0] d, input string req);
    @(negedge wclk);
    cfg_load = ld;
    wr_en    = en;
    wr_byte  = d;
    @(posedge wclk);
    @(negedge wclk);
    wr_en = 1'b0;
    if (ld && en) begin
      m[wpos] = d & keep_mask(wpos);
      wpos = (wpos + 1) % 4;
    end
    check_ofs(req);
  endtask

  task automatic rd_op(input logic ld, input logic en, input string req);
    @(negedge rclk);
    cfg_load = ld;
    rd_en    = en;
    @(posedge rclk);
    @(negedge rclk);
    rd_en = 1'b0;
    if (ld && en) begin
      exp_rd = m[rpos];
      rpos = (rpos + 1) % 4;
    end
    check(req, int'(rd_byte), int'(exp_rd));
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 1'b0;
    cfg_load = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    model_reset();
    #1;
    check("R1 reset empty_ofs", int'(empty_ofs), 7);
    check("R1 reset full_ofs", int'(full_ofs), 7);
    check("R1 reset rd_byte", int'(rd_byte), 0);
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    do_reset();

    // R1 / R6: first read returns the empty-low default.
    rd_op(1'b1, 1'b1, "R1 R6 first read");
    // R7: read enable without load holds the output.
    rd_op(1'b0, 1'b1, "R7 hold no load");
    rd_op(1'b1, 1'b0, "R7 hold no enable");

    // R2 / R8: full programming pass, high bytes over-driven.
    wr_op(1'b1, 1'b1, 8'hA5, "R2 empty low");
    wr_op(1'b1, 1'b1, 8'hFF, "R2 R8 empty high masked");
    check("R8 empty_ofs", int'(empty_ofs), 12'hFA5);
    wr_op(1'b1, 1'b1, 8'h3C, "R2 full low");
    wr_op(1'b1, 1'b1, 8'h92, "R2 R8 full high masked");
    check("R8 full_ofs", int'(full_ofs), 12'h23C);
    // R3: wrap to empty low.
    wr_op(1'b1, 1'b1, 8'h11, "R3 wrap to empty low");
    check("R3 empty_ofs", int'(empty_ofs), 12'hF11);
    // R4: load without write enable.
    wr_op(1'b1, 1'b0, 8'hEE, "R4 no-op");
    // R5: release load, write enable ignored, then resume at empty high.
    wr_op(1'b0, 1'b1, 8'h77, "R5 ignored while released");
    wr_op(1'b0, 1'b1, 8'h66, "R5 ignored while released");
    wr_op(1'b1, 1'b1, 8'h05, "R5 resume at empty high");
    check("R5 empty_ofs", int'(empty_ofs), 12'h511);

    // R6 / R8: read back through the sequence from its current position.
    for (int i = 0; i < 5; i++) rd_op(1'b1, 1'b1, "R6 R8 read sequence");

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      k = $urandom_range(0, 5);
      case (k)
        0, 1: wr_op(1'b1, 1'b1, 8'($urandom), "R2 R3 random write");
        2:    wr_op(1'b1, 1'b0, 8'($urandom), "R4 random no-op");
        3:    wr_op(1'b0, 1'($urandom), 8'($urandom), "R5 random released");
        4:    rd_op(1'b1, 1'b1, "R6 random read");
        default: rd_op(1'($urandom), 1'b0, "R7 random hold");
      endcase
    end

    // R1: reset after programming restores defaults and positions.
    do_reset();
    rd_op(1'b1, 1'b1, "R1 read after re-reset");
    wr_op(1'b1, 1'b1, 8'h09, "R1 write position after re-reset");
    check("R1 empty_ofs after re-reset write", int'(empty_ofs), 9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule